// File: doc/BRIEF.md
# PCIe Configuration Window Address Translator

The block turns host accesses that land in a 64 KB configuration window into the address word a PCIe core expects when it drives configuration requests, plus a flag that says whether the request is type 0 or type 1. The target bus, device and function do not come from the host address. Each 4 KB region in the lower half of the window has its own 16-bit selector register, and that register supplies them. The same region number also decides the request type.

Software first writes the window base and the selectors through a small word-addressed register port. It then reads or writes inside the window. Each host access gives, one cycle later, one of two results: a one-cycle valid strobe with the translated address and type, or a one-cycle decode-miss strobe.

Top module: `cfgwin_xlate`

## Requirements
- R1: After reset, cfg_valid, cfg_miss, cfg_type1 and cfg_addr are zero, and every register word reads zero.
- R2: An access hits when hst_addr[31:16] equals the programmed base and hst_addr[15] is 0. The cycle after the access, cfg_valid is high for exactly one cycle and cfg_miss stays low.
- R3: An access whose hst_addr[31:16] differs from the base, or whose hst_addr[15] is 1, gives no cfg_valid. Instead it raises cfg_miss for exactly the next cycle.
- R4: On a hit, cfg_addr[31:16] equals the selector indexed by hst_addr[14:12]. The selector's bits are bus in [15:8], device in [7:3] and function in [2:0], so they land at cfg_addr[31:24], [23:19] and [18:16].
- R5: On a hit, cfg_addr[15:12] and cfg_addr[1:0] are zero, and cfg_addr[11:2] equals hst_addr[11:2].
- R6: On a hit, cfg_type1 is 0 when hst_addr[14:12] is zero and 1 otherwise.
- R7: Register word k+1 (k = 0..3) holds selector 2k in bits [15:0] and selector 2k+1 in bits [31:16]. A write loads both halves and a read returns them.
- R8: Register word 0 holds the window base in bits [31:16]. Its bits [15:0] read zero. Words 5 to 7 read zero and ignore writes.
- R9: If a host access and a selector write fall in the same cycle, the access is translated with the selector value from before the write.
- R10: While cfg_valid is low, cfg_addr and cfg_type1 hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| hst_valid | input | 1 | Host access strobe, one cycle per access |
| hst_addr | input | 32 | Host byte address |
| cfg_valid | output | 1 | Translated request valid, one cycle |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_type1 | output | 1 | 1 = type 1 request, 0 = type 0 |
| cfg_miss | output | 1 | Decode-miss strobe, one cycle |

## Verification
A selector write and a host access can fall in the same cycle, and both touch the same selector storage. The bench provokes this by driving a write to the pair word that holds selector 1 in the same cycle as an access to region 1. It then expects the translated address to carry the old selector. A second access right after must carry the new value.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int N_SEL    = 8;
    localparam int REGION_W = 12;
    localparam int IDX_W    = $clog2(N_SEL);
    localparam int N_WORDS  = N_SEL / 2 + 1;
    localparam int REG_AW   = $clog2(N_WORDS);

    typedef logic [N_SEL-1:0][SEL_W-1:0] sel_bank_t;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic              type1;
        logic [ADDR_W-1:0] addr;
    } cfg_out_t;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
    import cfgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [SEL_W-1:0]  base_o,
    output sel_bank_t         sel_o
);
    typedef struct packed {
        logic [SEL_W-1:0] base;
        sel_bank_t        sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            if (reg_addr == '0)
                st_d.base = reg_wdata[31:16];
            for (int k = 0; k < N_SEL / 2; k++) begin
                if (reg_addr == REG_AW'(k + 1)) begin
                    st_d.sel[2*k]   = reg_wdata[15:0];
                    st_d.sel[2*k+1] = reg_wdata[31:16];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0)
            reg_rdata = {st_q.base, 16'h0000};
        for (int k = 0; k < N_SEL / 2; k++) begin
            if (reg_addr == REG_AW'(k + 1))
                reg_rdata = {st_q.sel[2*k+1], st_q.sel[2*k]};
        end
    end

    assign base_o = st_q.base;
    assign sel_o  = st_q.sel;
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
    import cfgwin_pkg::*;
(
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [SEL_W-1:0]  base_i,
    input  sel_bank_t         sel_i,
    output logic              hit_o,
    output logic              type1_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int WIN_W  = REGION_W + IDX_W + 1;
    localparam int HALF_B = REGION_W + IDX_W;
    localparam int PAD_W  = ADDR_W - SEL_W - REGION_W;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = hst_addr[REGION_W +: IDX_W];
        hit_o   = (hst_addr[ADDR_W-1:WIN_W] == base_i[SEL_W-1:WIN_W-SEL_W])
                  && !hst_addr[HALF_B];
        type1_o = (idx != '0);
        addr_o  = {sel_i[idx], {PAD_W{1'b0}}, hst_addr[REGION_W-1:2], 2'b00};
    end
endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
    import cfgwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hst_valid,
    input  logic [ADDR_W-1:0] hst_addr,
    output logic              cfg_valid,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic              cfg_type1,
    output logic              cfg_miss
);
    logic [SEL_W-1:0]  base;
    sel_bank_t         sel;
    logic              hit;
    logic              type1;
    logic [ADDR_W-1:0] xaddr;
    cfg_out_t          out_d, out_q;

    cfgwin_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_o    (base),
        .sel_o     (sel)
    );

    cfgwin_decode u_dec (
        .hst_addr (hst_addr),
        .base_i   (base),
        .sel_i    (sel),
        .hit_o    (hit),
        .type1_o  (type1),
        .addr_o   (xaddr)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = hst_valid && hit;
        out_d.miss  = hst_valid && !hit;
        if (hst_valid && hit) begin
            out_d.addr  = xaddr;
            out_d.type1 = type1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cfg_valid = out_q.valid;
    assign cfg_miss  = out_q.miss;
    assign cfg_type1 = out_q.type1;
    assign cfg_addr  = out_q.addr;
endmodule

// File: rtl/cfgwin_xlate_chk.sv
module cfgwin_xlate_chk
    import cfgwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hst_valid,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              cfg_valid,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_type1,
    input logic              cfg_miss
);
    assert_valid_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && cfg_miss));

    assert_valid_from_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(hst_valid));

    assert_miss_from_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_miss |-> $past(hst_valid));

    assert_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[15:12] == 4'h0 && cfg_addr[1:0] == 2'b00));

    assert_reg_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[11:2] == $past(hst_addr[11:2])));

    assert_type_from_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_type1 == ($past(hst_addr[14:12]) != 3'd0)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> ($stable(cfg_addr) && $stable(cfg_type1)));
endmodule

bind cfgwin_xlate cfgwin_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_valid (hst_valid),
    .hst_addr  (hst_addr),
    .cfg_valid (cfg_valid),
    .cfg_addr  (cfg_addr),
    .cfg_type1 (cfg_type1),
    .cfg_miss  (cfg_miss)
);

// File: tb/cfgwin_xlate_bench.sv
module cfgwin_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hst_valid = 1'b0;
    logic [31:0] hst_addr = '0;
    logic        cfg_valid;
    logic [31:0] cfg_addr;
    logic        cfg_type1;
    logic        cfg_miss;

    int total = 0;
    int bad   = 0;

    logic [15:0] sel_m [8];
    logic [15:0] base_m;

    always #2 clk = ~clk;

    cfgwin_xlate u_cfgwin_xlate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hst_valid(hst_valid),
        .hst_addr(hst_addr), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
        .cfg_type1(cfg_type1), .cfg_miss(cfg_miss)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd0) base_m = d[31:16];
        else if (a <= 3'd4) begin
            sel_m[2*(a-1)]   = d[15:0];
            sel_m[2*(a-1)+1] = d[31:16];
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] xl(input logic [31:0] a);
        return {sel_m[a[14:12]], 4'h0, a[11:2], 2'b00};
    endfunction

    task automatic hit_access(input string req, input logic [31:0] a);
        @(negedge clk);
        hst_valid = 1'b1; hst_addr = a;
        @(negedge clk);
        hst_valid = 1'b0;
        check({req, " valid"}, {31'd0, cfg_valid}, 32'd1);
        check({req, " miss"},  {31'd0, cfg_miss},  32'd0);
        check({req, " addr"},  cfg_addr, xl(a));
        check({req, " type"},  {31'd0, cfg_type1}, {31'd0, a[14:12] != 3'd0});
        @(negedge clk);
        check({req, " one-cycle valid"}, {31'd0, cfg_valid}, 32'd0);
    endtask

    task automatic miss_access(input logic [31:0] a);
        logic [31:0] prev_addr;
        logic        prev_type;
        prev_addr = cfg_addr; prev_type = cfg_type1;
        @(negedge clk);
        hst_valid = 1'b1; hst_addr = a;
        @(negedge clk);
        hst_valid = 1'b0;
        check("R3 miss flag", {31'd0, cfg_miss}, 32'd1);
        check("R3 no valid", {31'd0, cfg_valid}, 32'd0);
        check("R10 addr held", cfg_addr, prev_addr);
        check("R10 type held", {31'd0, cfg_type1}, {31'd0, prev_type});
        @(negedge clk);
        check("R3 one-cycle miss", {31'd0, cfg_miss}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 valid", {31'd0, cfg_valid}, 32'd0);
        check("R1 miss", {31'd0, cfg_miss}, 32'd0);
        check("R1 type", {31'd0, cfg_type1}, 32'd0);
        check("R1 addr", cfg_addr, 32'd0);
        for (int i = 0; i < 8; i++) rd_check("R1 regs zero", 3'(i), 32'd0);
    endtask

    task automatic t_regs;
        wr(3'd0, 32'hA5C3_FFFF);
        rd_check("R8 base readback", 3'd0, 32'hA5C3_0000);
        wr(3'd1, 32'h0208_0000);
        wr(3'd2, 32'h0310_0411);
        wr(3'd3, 32'h05F8_0602);
        wr(3'd4, 32'hFFFF_0A1B);
        rd_check("R7 pair0", 3'd1, 32'h0208_0000);
        rd_check("R7 pair1", 3'd2, 32'h0310_0411);
        rd_check("R7 pair2", 3'd3, 32'h05F8_0602);
        rd_check("R7 pair3", 3'd4, 32'hFFFF_0A1B);
        wr(3'd6, 32'h1234_5678);
        rd_check("R8 word6 ignored", 3'd6, 32'd0);
        rd_check("R8 pair0 untouched", 3'd1, 32'h0208_0000);
    endtask

    task automatic t_hits;
        hit_access("R4 R5 R6 region0 type0", 32'hA5C3_0ABC);
        hit_access("R4 R6 region1", 32'hA5C3_1004);
        hit_access("R4 region3", 32'hA5C3_3FFF);
        hit_access("R4 region6", 32'hA5C3_6100);
        hit_access("R4 R5 region7", 32'hA5C3_7FFC);
        hit_access("R2 region5", 32'hA5C3_5003);
    endtask

    task automatic t_miss;
        miss_access(32'hA5C2_0000);
        miss_access(32'hA5C3_8000);
        miss_access(32'hA5C3_F004);
        miss_access(32'h0000_1000);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h7788_1122;
        hst_valid = 1'b1; hst_addr = 32'hA5C3_1010;
        @(negedge clk);
        reg_we = 1'b0; hst_valid = 1'b0;
        check("R9 old selector used", cfg_addr, {16'h0208, 4'h0, 10'h004, 2'b00});
        sel_m[0] = 16'h1122; sel_m[1] = 16'h7788;
        hit_access("R9 new selector after write", 32'hA5C3_1010);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sel_m[i] = '0;
        base_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_hits();
        t_miss();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule